// File: doc/BRIEF.md
# Readout Stream Consistency Checker

This block sits beside the byte stream that a readout controller hands out of its data FIFO. It sees every byte on the valid/ready handshake and takes no part in that handshake. A readout starts with one byte that holds the controller's clock count. After it come zero or more chip records. Each record is a 4-byte header followed by a run of 32-byte channel blocks. The block finds headers only by their position in the stream. To do that it works out, from the header itself, how many channel blocks follow it. It then checks each header field and each payload byte against the rules of the format. Software sets the expected trigger tag, whether full readout is on, whether test mode is on, and how many chip records a readout should carry.

Each rule has its own sticky error flag, and one synchronous clear input resets all of them. A counter reports how many chip records the current (or most recent) readout has carried. Each payload byte that is marked as TDC data has its 6-bit Gray-coded time converted to binary and shown on an output for one cycle.

Top module: `rsc_stream_check`

## Requirements
- R1: Byte 2 of every chip header must equal the readout's first byte plus one, modulo 256. A mismatch sets `err_flags[0]`.
- R2: Bits 4:0 of header byte 3 must equal `cfg_tag`. A mismatch sets `err_flags[1]`.
- R3: A nonzero lock-error sum in bits 6:5 of header byte 0 sets `err_flags[2]`.
- R4: A chip address above 5 in bits 2:0 of header byte 0 sets `err_flags[3]`. Address 5 is legal. The board address sits in bits 4:3.
- R5: Each header is followed by a number of 32-byte blocks. With `cfg_full` = 0 that number is the count of ones in the hit map (header byte 1). With `cfg_full` = 1 it is 8. If `mon_last` arrives anywhere other than the final byte of a record, `err_flags[4]` is set.
- R6: Buffer number = bits 6:5 of header byte 3. The first record of each readout must carry the previous readout's buffer number plus one, modulo 4. Every other record in a readout must carry the same buffer number as the first. A violation sets `err_flags[5]`. The first readout after a reset or clear is accepted with any buffer number.
- R7: Within one readout, chip addresses must rise strictly from record to record. A violation sets `err_flags[6]`.
- R8: `rec_count` gives the number of headers begun since the readout's first byte. When `mon_last` arrives, a count different from `cfg_chips` sets `err_flags[7]`.
- R9: With `cfg_test` = 1, each byte of a 32-byte block after the first must be greater than the byte before it. A violation sets `err_flags[8]`. With `cfg_test` = 0 this rule has no effect.
- R10: In the cycle after a payload byte with bit 6 set is accepted, `tdc_valid` is 1 and `tdc_value` holds the binary value of its Gray-coded bits 5:0. Clock and header bytes never raise `tdc_valid`.
- R11: Error flags stay set until `clr_err`. Asserting `clr_err` clears every flag and the buffer history.
- R12: A byte counts only in a cycle where `mon_valid` and `mon_ready` are both 1. Other cycles change neither the parse position nor any flag.
- R13: After reset, `err_flags` = 0, `rec_count` = 0 and `tdc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears the sticky flags and the buffer history |
| mon_valid | input | 1 | Stream valid, as observed |
| mon_ready | input | 1 | Stream ready, as observed |
| mon_data | input | 8 | Stream byte |
| mon_last | input | 1 | Marks the final byte of a readout |
| cfg_tag | input | 5 | Expected trigger tag |
| cfg_full | input | 1 | Full readout: 8 blocks per record |
| cfg_test | input | 1 | Test mode: blocks must strictly increase |
| cfg_chips | input | 4 | Expected number of records per readout |
| err_flags | output | 9 | Sticky error flags, one per rule |
| rec_count | output | 4 | Records begun in the current readout |
| tdc_valid | output | 1 | Accepted TDC byte in the previous cycle |
| tdc_value | output | 6 | Binary-decoded TDC time |

## Verification
Most internal faults surface as a wrong parse position, and a wrong position quickly shows up as false flags. If the count of remaining blocks is off, the next header is read from payload bytes, so the clock, tag or length flag is raised by the end of that readout at the latest. If the stored clock byte, previous chip address or buffer history is corrupt, the flag goes wrong in the cycle after the header byte that uses it. If the Gray decoder or the byte-type gating is wrong, `tdc_value` or `tdc_valid` is wrong one cycle after the affected byte. The directed scenarios therefore read the flags right after each readout's last byte, and read the TDC outputs right after single bytes.

// File: rtl/rsc_pkg.sv
// Shared definitions for the readout stream checker.
// Flag positions are fixed because software decodes err_flags by bit.
package rsc_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_ERR = 9;

    localparam int E_CLK   = 0;
    localparam int E_TAG   = 1;
    localparam int E_LOCK  = 2;
    localparam int E_ADDR  = 3;
    localparam int E_LEN   = 4;
    localparam int E_BUF   = 5;
    localparam int E_ORDER = 6;
    localparam int E_COUNT = 7;
    localparam int E_MONO  = 8;

    // Where the next accepted byte falls within a readout.
    typedef enum logic [1:0] {
        POS_CLK = 2'd0,
        POS_HDR = 2'd1,
        POS_PAY = 2'd2
    } pos_e;

    typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/rsc_gray2bin.sv
// Gray-to-binary converter of parameterized width.
// It is purely combinational. Output bit i is the XOR of all input bits
// from the top down to bit i.
module rsc_gray2bin #(
    parameter int W = 6
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Each output bit is the prefix parity of the Gray bits above it.
        assign bin_o[i] = ^gray_i[W-1:i];
    end
endmodule

// File: rtl/rsc_framer.sv
// Tracks the position of each accepted byte within a readout.
// The positions are: clock byte, header byte 0..3, payload byte 0..BLK_BYTES-1.
// When a header finishes, the framer sets the number of payload blocks,
// taken from the hit map or from full-readout mode. It flags a last byte
// that arrives anywhere other than the end of a record, and a record count
// at the last byte that differs from the configured one.
// Assumes the hit map fits in one byte (CH_PER_CHIP <= 8) and the header
// is 4 bytes long.
module rsc_framer
    import rsc_pkg::*;
#(
    parameter int BLK_BYTES   = 32,
    parameter int CH_PER_CHIP = 8,
    parameter int CNT_W       = 4,
    localparam int BIDX_W     = $clog2(BLK_BYTES),
    localparam int BLK_W      = $clog2(CH_PER_CHIP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              last_i,
    input  logic              cfg_full_i,
    input  logic [CNT_W-1:0]  cfg_chips_i,
    output pos_e              pos_o,
    output logic [1:0]        hdr_idx_o,
    output logic [BIDX_W-1:0] byte_idx_o,
    output logic              first_rec_o,
    output logic [CNT_W-1:0]  rec_count_o,
    output logic              len_err_o,
    output logic              cnt_err_o
);
    localparam logic [1:0]        HDR_LAST  = 2'd3;
    localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(BLK_BYTES - 1);

    pos_e              pos_q, pos_d;
    logic [1:0]        hidx_q, hidx_d;
    logic [BIDX_W-1:0] bidx_q, bidx_d;
    logic [BLK_W-1:0]  left_q, left_d;
    logic [CNT_W-1:0]  rec_q, rec_d;
    logic [CH_PER_CHIP-1:0] hit_q;
    logic [BLK_W-1:0]  hit_ones;
    logic [BLK_W-1:0]  nblk;
    logic              evt_end;
    logic              end_ok;

    // Population count of the stored hit map.
    always_comb begin
        hit_ones = '0;
        for (int i = 0; i < CH_PER_CHIP; i++) begin
            hit_ones = hit_ones + BLK_W'(hit_q[i]);
        end
    end

    // Number of blocks that follow the header now being completed.
    assign nblk = cfg_full_i ? BLK_W'(CH_PER_CHIP) : hit_ones;

    // Whether the current byte is a legal place for a readout to end.
    assign end_ok = (pos_q == POS_HDR && hidx_q == HDR_LAST && nblk == '0) ||
                    (pos_q == POS_PAY && bidx_q == BIDX_LAST && left_q == BLK_W'(1)) ||
                    (pos_q == POS_CLK);

    // Next position, record count and end-of-readout outcome.
    always_comb begin
        pos_d   = pos_q;
        hidx_d  = hidx_q;
        bidx_d  = bidx_q;
        left_d  = left_q;
        rec_d   = rec_q;
        evt_end = 1'b0;
        if (beat_i) begin
            unique case (pos_q)
                POS_CLK: begin
                    rec_d  = '0;
                    hidx_d = '0;
                    pos_d  = POS_HDR;
                end
                POS_HDR: begin
                    if (hidx_q == 2'd0 && rec_q != '1) begin
                        rec_d = rec_q + 1'b1;
                    end
                    if (hidx_q == HDR_LAST) begin
                        hidx_d = '0;
                        if (nblk != '0) begin
                            pos_d  = POS_PAY;
                            left_d = nblk;
                            bidx_d = '0;
                        end
                    end else begin
                        hidx_d = hidx_q + 2'd1;
                    end
                end
                POS_PAY: begin
                    if (bidx_q == BIDX_LAST) begin
                        bidx_d = '0;
                        left_d = left_q - 1'b1;
                        if (left_q == BLK_W'(1)) begin
                            pos_d = POS_HDR;
                        end
                    end else begin
                        bidx_d = bidx_q + 1'b1;
                    end
                end
                default: pos_d = POS_CLK;
            endcase
            if (last_i) begin
                evt_end = 1'b1;
                pos_d   = POS_CLK;
            end
        end
    end

    // Position state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_CLK;
            hidx_q <= '0;
            bidx_q <= '0;
            left_q <= '0;
            rec_q  <= '0;
        end else begin
            pos_q  <= pos_d;
            hidx_q <= hidx_d;
            bidx_q <= bidx_d;
            left_q <= left_d;
            rec_q  <= rec_d;
        end
    end

    // Capture the hit map from header byte 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else if (beat_i && pos_q == POS_HDR && hidx_q == 2'd1) begin
            hit_q <= data_i[CH_PER_CHIP-1:0];
        end
    end

    assign pos_o       = pos_q;
    assign hdr_idx_o   = hidx_q;
    assign byte_idx_o  = bidx_q;
    assign rec_count_o = rec_q;
    assign first_rec_o = (hidx_q == 2'd0) ? (rec_q == '0) : (rec_q == CNT_W'(1));
    assign len_err_o   = evt_end && !end_ok;
    assign cnt_err_o   = evt_end && (rec_d != cfg_chips_i);
endmodule

// File: rtl/rsc_rules.sv
// Checks each header and payload byte against the field rules: clock echo,
// trigger tag, lock sum, chip address range, ascending chip order,
// buffer rotation and strictly increasing test-mode blocks.
// It outputs one pulse per rule in the cycle the offending byte is accepted.
// Assumes the framer supplies the byte position and the first-record marker.
module rsc_rules
    import rsc_pkg::*;
#(
    parameter int BIDX_W   = 5,
    parameter int MAX_CHIP = 5,
    parameter int TAG_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    input  pos_e              pos_i,
    input  logic [1:0]        hdr_idx_i,
    input  logic [BIDX_W-1:0] byte_idx_i,
    input  logic              first_rec_i,
    input  logic [TAG_W-1:0]  cfg_tag_i,
    input  logic              cfg_test_i,
    output err_vec_t          hit_o
);
    logic [DATA_W-1:0] clk_q;
    logic [2:0]        chip_q;
    logic [1:0]        buf_q;
    logic              buf_have_q;
    logic [DATA_W-1:0] prev_q;

    wire hdr_beat = beat_i && pos_i == POS_HDR;
    wire pay_beat = beat_i && pos_i == POS_PAY;

    // Rule evaluation for the byte accepted this cycle.
    always_comb begin
        hit_o = '0;
        if (hdr_beat) begin
            unique case (hdr_idx_i)
                2'd0: begin
                    hit_o[E_LOCK]  = data_i[6:5] != 2'd0;
                    hit_o[E_ADDR]  = data_i[2:0] > 3'(MAX_CHIP);
                    hit_o[E_ORDER] = !first_rec_i && data_i[2:0] <= chip_q;
                end
                2'd2: hit_o[E_CLK] = data_i != clk_q + 8'd1;
                2'd3: begin
                    hit_o[E_TAG] = data_i[TAG_W-1:0] != cfg_tag_i;
                    hit_o[E_BUF] = first_rec_i ? (buf_have_q && data_i[6:5] != buf_q + 2'd1)
                                               : (data_i[6:5] != buf_q);
                end
                default: ;
            endcase
        end
        if (pay_beat) begin
            hit_o[E_MONO] = cfg_test_i && byte_idx_i != '0 && data_i <= prev_q;
        end
    end

    // Remember the controller clock byte and the last chip address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= '0;
            chip_q <= '0;
        end else begin
            if (beat_i && pos_i == POS_CLK) clk_q <= data_i;
            if (hdr_beat && hdr_idx_i == 2'd0) chip_q <= data_i[2:0];
        end
    end

    // Buffer-number history; the first record of a readout sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_have_q <= 1'b0;
        end else if (clr_i) begin
            buf_have_q <= 1'b0;
        end else if (hdr_beat && hdr_idx_i == 2'd3 && first_rec_i) begin
            buf_q      <= data_i[6:5];
            buf_have_q <= 1'b1;
        end
    end

    // Previous payload byte for the increasing-sequence rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (pay_beat) begin
            prev_q <= data_i;
        end
    end
endmodule

// File: rtl/rsc_stream_check.sv
// Top of the readout stream checker. It is a passive observer of a
// valid/ready byte stream. It holds one sticky flag per rule and drives
// the decoded TDC time for each accepted TDC payload byte.
// Assumes the byte format fixes a 5-bit tag, 3-bit chip address and 6-bit value.
module rsc_stream_check
    import rsc_pkg::*;
#(
    parameter int BLK_BYTES   = 32,
    parameter int CH_PER_CHIP = 8,
    parameter int MAX_CHIP    = 5,
    parameter int CNT_W       = 4,
    parameter int TAG_W       = 5,
    parameter int VAL_W       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_err,
    input  logic               mon_valid,
    input  logic               mon_ready,
    input  logic [7:0]         mon_data,
    input  logic               mon_last,
    input  logic [TAG_W-1:0]   cfg_tag,
    input  logic               cfg_full,
    input  logic               cfg_test,
    input  logic [CNT_W-1:0]   cfg_chips,
    output logic [NUM_ERR-1:0] err_flags,
    output logic [CNT_W-1:0]   rec_count,
    output logic               tdc_valid,
    output logic [VAL_W-1:0]   tdc_value
);
    localparam int BIDX_W = $clog2(BLK_BYTES);

    logic              beat;
    pos_e              pos;
    logic [1:0]        hdr_idx;
    logic [BIDX_W-1:0] byte_idx;
    logic              first_rec;
    logic              len_err;
    logic              cnt_err;
    err_vec_t          rule_hit;
    err_vec_t          all_hit;
    err_vec_t          err_q;
    logic [VAL_W-1:0]  val_bin;
    logic              tdc_v_q;
    logic [VAL_W-1:0]  tdc_val_q;

    assign beat = mon_valid && mon_ready;

    rsc_framer #(
        .BLK_BYTES   (BLK_BYTES),
        .CH_PER_CHIP (CH_PER_CHIP),
        .CNT_W       (CNT_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_i      (beat),
        .data_i      (mon_data),
        .last_i      (mon_last),
        .cfg_full_i  (cfg_full),
        .cfg_chips_i (cfg_chips),
        .pos_o       (pos),
        .hdr_idx_o   (hdr_idx),
        .byte_idx_o  (byte_idx),
        .first_rec_o (first_rec),
        .rec_count_o (rec_count),
        .len_err_o   (len_err),
        .cnt_err_o   (cnt_err)
    );

    rsc_rules #(
        .BIDX_W   (BIDX_W),
        .MAX_CHIP (MAX_CHIP),
        .TAG_W    (TAG_W)
    ) u_rules (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_err),
        .beat_i      (beat),
        .data_i      (mon_data),
        .pos_i       (pos),
        .hdr_idx_i   (hdr_idx),
        .byte_idx_i  (byte_idx),
        .first_rec_i (first_rec),
        .cfg_tag_i   (cfg_tag),
        .cfg_test_i  (cfg_test),
        .hit_o       (rule_hit)
    );

    rsc_gray2bin #(.W(VAL_W)) u_gray (
        .gray_i (mon_data[VAL_W-1:0]),
        .bin_o  (val_bin)
    );

    // Merge the framer's structural errors with the field-rule pulses.
    always_comb begin
        all_hit         = rule_hit;
        all_hit[E_LEN]   = len_err;
        all_hit[E_COUNT] = cnt_err;
    end

    // Sticky flags; clear has priority over a new error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (clr_err) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | all_hit;
        end
    end

    // One-cycle decoded TDC output for payload bytes with the type bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdc_v_q   <= 1'b0;
            tdc_val_q <= '0;
        end else begin
            tdc_v_q <= beat && pos == POS_PAY && mon_data[6];
            if (beat && pos == POS_PAY && mon_data[6]) tdc_val_q <= val_bin;
        end
    end

    assign err_flags = err_q;
    assign tdc_valid = tdc_v_q;
    assign tdc_value = tdc_val_q;
endmodule

// File: rtl/rsc_stream_check_sva.sv
// Assertion checker for rsc_stream_check. It observes ports only.
module rsc_stream_check_sva #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_err,
    input logic             mon_valid,
    input logic             mon_ready,
    input logic [8:0]       err_flags,
    input logic [CNT_W-1:0] rec_count,
    input logic             tdc_valid
);
    AST_TDC_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        tdc_valid |-> $past(mon_valid && mon_ready)); // R10

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_err) |-> ((err_flags & $past(err_flags)) == $past(err_flags))); // R11

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_err) |-> (err_flags == '0)); // R11

    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mon_valid && mon_ready) && !clr_err) |=> $stable(err_flags)); // R12

    AST_IDLE_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_valid && mon_ready) |=> $stable(rec_count)); // R12
endmodule

bind rsc_stream_check rsc_stream_check_sva #(.CNT_W(CNT_W)) u_sva (.*);

// File: tb/rsc_stream_check_tb_top.sv
`timescale 1ns/1ps
module rsc_stream_check_tb_top;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 1'b0;
    logic mon_valid = 1'b0;
    logic mon_ready = 1'b0;
    logic mon_last = 1'b0;
    logic [7:0] mon_data = '0;
    logic [4:0] cfg_tag = 5'd7;
    logic cfg_full = 1'b0;
    logic cfg_test = 1'b0;
    logic [CNT_W-1:0] cfg_chips = 4'd1;
    logic [8:0] err_flags;
    logic [CNT_W-1:0] rec_count;
    logic tdc_valid;
    logic [5:0] tdc_value;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rsc_stream_check dut_i (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .mon_valid(mon_valid), .mon_ready(mon_ready), .mon_data(mon_data), .mon_last(mon_last),
        .cfg_tag(cfg_tag), .cfg_full(cfg_full), .cfg_test(cfg_test), .cfg_chips(cfg_chips),
        .err_flags(err_flags), .rec_count(rec_count), .tdc_valid(tdc_valid), .tdc_value(tdc_value)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic l);
        @(negedge clk);
        mon_valid = 1'b1; mon_ready = 1'b1; mon_data = d; mon_last = l;
    endtask

    task automatic idle();
        @(negedge clk);
        mon_valid = 1'b0; mon_ready = 1'b1; mon_last = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        mon_valid = 1'b0; mon_last = 1'b0; clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    task automatic hdr(input int lock, input int board, input int chip, input int hit,
                       input int clkb, input int bufn, input int tag, input logic l);
        put(8'((lock << 5) | (board << 3) | chip), 1'b0);
        put(8'(hit), 1'b0);
        put(8'(clkb), 1'b0);
        put(8'((bufn << 5) | tag), l);
    endtask

    task automatic blocks(input int n, input int start, input int step, input logic l);
        for (int b = 0; b < n; b++)
            for (int j = 0; j < 32; j++)
                put(8'(start + j * step), l && b == n - 1 && j == 31);
    endtask

    task automatic evt1(input int clkb, input int hclk, input int chip, input int bufn, input int tag);
        put(8'(clkb), 1'b0);
        hdr(0, 0, chip, 0, hclk, bufn, tag, 1'b1);
        idle();
    endtask

    task automatic t_reset();
        chk("R13 flags after reset", int'(err_flags), 0);
        chk("R13 rec_count after reset", int'(rec_count), 0);
        chk("R13 tdc_valid after reset", int'(tdc_valid), 0);
    endtask

    task automatic t_good();
        clear();
        cfg_chips = 4'd2; cfg_test = 1'b1; cfg_full = 1'b0;
        put(8'h10, 1'b0);
        hdr(0, 1, 0, 8'h05, 8'h11, 0, 7, 1'b0);
        blocks(2, 0, 1, 1'b0);
        hdr(0, 1, 1, 8'h00, 8'h11, 0, 7, 1'b1);
        idle();
        chk("R5 R1 R9 clean two-record readout", int'(err_flags), 0);
        chk("R8 rec_count two records", int'(rec_count), 2);
        cfg_test = 1'b0;
    endtask

    task automatic t_clk();
        clear();
        cfg_chips = 4'd1;
        evt1(8'hFF, 8'h00, 0, 0, 7);
        chk("R1 clock echo wraps 0xFF to 0x00", int'(err_flags), 0);
        evt1(8'h20, 8'h20, 0, 1, 7);
        chk("R1 clock echo mismatch", int'(err_flags), 9'h001);
        evt1(8'h30, 8'h31, 0, 2, 7);
        chk("R11 flag stays after good readout", int'(err_flags), 9'h001);
        clear();
        chk("R11 clear empties flags", int'(err_flags), 0);
    endtask

    task automatic t_tag();
        clear();
        evt1(1, 2, 0, 0, 5);
        chk("R2 tag mismatch", int'(err_flags), 9'h002);
    endtask

    task automatic t_lock_addr();
        clear();
        put(8'h01, 1'b0);
        hdr(2, 0, 0, 0, 2, 0, 7, 1'b1);
        idle();
        chk("R3 lock sum nonzero", int'(err_flags), 9'h004);
        clear();
        evt1(1, 2, 6, 0, 7);
        chk("R4 chip address 6", int'(err_flags), 9'h008);
        clear();
        evt1(1, 2, 5, 0, 7);
        chk("R4 chip address 5 legal", int'(err_flags), 0);
    endtask

    task automatic t_len();
        clear();
        cfg_full = 1'b0;
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 8'h03, 2, 0, 7, 1'b0);
        blocks(1, 0, 1, 1'b1);
        idle();
        chk("R5 one block for two hits", int'(err_flags), 9'h010);
        clear();
        cfg_full = 1'b1;
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 8'h01, 2, 0, 7, 1'b0);
        blocks(8, 0, 1, 1'b1);
        idle();
        chk("R5 full readout eight blocks", int'(err_flags), 0);
        clear();
        cfg_full = 1'b0;
        put(8'h01, 1'b0);
        put(8'h00, 1'b0);
        put(8'h00, 1'b1);
        idle();
        chk("R5 last inside header", int'(err_flags), 9'h010);
    endtask

    task automatic t_buf();
        clear();
        for (int b = 0; b < 5; b++) evt1(1, 2, 0, b % 4, 7);
        chk("R6 rotation 0 1 2 3 0", int'(err_flags), 0);
        evt1(1, 2, 0, 2, 7);
        chk("R6 rotation skip", int'(err_flags), 9'h020);
    endtask

    task automatic t_order();
        clear();
        cfg_chips = 4'd2;
        put(8'h01, 1'b0);
        hdr(0, 0, 3, 0, 2, 0, 7, 1'b0);
        hdr(0, 0, 1, 0, 2, 0, 7, 1'b1);
        idle();
        chk("R7 descending chip order", int'(err_flags), 9'h040);
    endtask

    task automatic t_count();
        clear();
        cfg_chips = 4'd3;
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 0, 2, 0, 7, 1'b0);
        hdr(0, 0, 1, 0, 2, 0, 7, 1'b1);
        idle();
        chk("R8 two records for three expected", int'(err_flags), 9'h080);
        chk("R8 rec_count", int'(rec_count), 2);
        cfg_chips = 4'd1;
    endtask

    task automatic t_mono();
        clear();
        cfg_test = 1'b1;
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 8'h01, 2, 0, 7, 1'b0);
        blocks(1, 9, 0, 1'b1);
        idle();
        chk("R9 flat block in test mode", int'(err_flags), 9'h100);
        clear();
        cfg_test = 1'b0;
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 8'h01, 2, 0, 7, 1'b0);
        blocks(1, 9, 0, 1'b1);
        idle();
        chk("R9 flat block ignored outside test mode", int'(err_flags), 0);
    endtask

    task automatic t_gray();
        clear();
        put(8'h01, 1'b0);
        hdr(0, 0, 0, 8'h01, 2, 0, 7, 1'b0);
        for (int j = 0; j < 30; j++) put(8'(j), 1'b0);
        put(8'h60, 1'b0);
        idle();
        chk("R10 tdc_valid for type bit", int'(tdc_valid), 1);
        chk("R10 gray 100000 -> 63", int'(tdc_value), 63);
        put(8'h7B, 1'b1);
        idle();
        chk("R10 gray 111011 -> 45", int'(tdc_value), 45);
        put(8'h45, 1'b0);
        idle();
        chk("R10 clock byte gives no tdc_valid", int'(tdc_valid), 0);
        hdr(0, 0, 0, 0, 8'h46, 1, 7, 1'b1);
        idle();
        chk("R10 stream stays clean", int'(err_flags), 0);
    endtask

    task automatic t_hs();
        clear();
        put(8'h01, 1'b0);
        put(8'h00, 1'b0);
        put(8'h00, 1'b0);
        @(negedge clk);
        mon_valid = 1'b1; mon_ready = 1'b0; mon_data = 8'h99; mon_last = 1'b1;
        put(8'h02, 1'b0);
        put(8'h07, 1'b1);
        idle();
        chk("R12 stalled byte ignored", int'(err_flags), 0);
        chk("R12 rec_count after stall", int'(rec_count), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_clk();
        t_tag();
        t_lock_addr();
        t_len();
        t_buf();
        t_order();
        t_count();
        t_mono();
        t_gray();
        t_hs();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule